// File: doc/BRIEF.md
# Descriptor Ring Transfer Sequencer

This block walks a circular ring of 16-byte transfer descriptors kept in system memory. Software programs where the ring lives and how many entries it holds through a small 32-bit register window. It then moves a software-owned head index forward and sets a run bit. The block keeps its own tail index. For every entry between tail and head it reads the four descriptor words over a simple word-wide memory port and hands the whole descriptor to an external transaction engine over a request/done handshake. It then writes the engine's 32-bit outcome word back into bytes 4 to 7 of the same entry and only after that advances the tail.

Descriptor byte 3 carries per-entry control flags. Bit 6 asks for a completion flag, and bit 7 asks the ring to halt if the entry fails. The low bit of the returned outcome byte (descriptor byte 4) means success. Two sticky flags in the status register report completion and error, and software clears each one by writing 1 to it.

Top module: `desc_ring_ctl`

## Requirements
- R1: After reset, every register reads zero: ring base (0x100 low half, 0x104 high half), control (0x108), status (0x10C) and ring size (0x110).
- R2: Entry i is fetched as four 32-bit reads at ring base + 16*i + 0, 4, 8, 12, where the base is {0x104 value, 0x100 value}. The descriptor presented to the engine holds the word at offset 0 in bits 31:0, up to the word at offset 12 in bits 127:96. Both base halves read back as written.
- R3: The size register holds the index of the last entry (entry count minus one) in bits 7:0. The tail moves from that index to 0.
- R4: Control bit 0 (run) and head index bits 23:16 govern processing. While run is 1 the block processes entries until its tail equals the head. While run is 0 no fetch starts and the tail stays put.
- R5: After the engine reports done, the block writes the engine's outcome word to entry address + 4. The tail, visible in status bits 23:16, advances only once that write is acknowledged.
- R6: Status bit 5 becomes 1 after the write-back of an entry whose byte 3 bit 6 is 1, and is not set by entries with that bit 0.
- R7: Status bit 4 becomes 1 after the write-back of an entry whose outcome bit 0 is 0 while control bit 4 (error enable) is 1. With error enable 0 it stays 0.
- R8: Writing 1 to status bit 5 or bit 4 clears only that bit; writing 0 leaves it.
- R9: When a failing entry has byte 3 bit 7 set, the block clears the run bit, stops with the tail one past the failed entry, and starts no further entry.
- R10: Status bit 0 (busy) is 1 from the first fetch until the ring is empty or halted, and the memory port and the engine are never requested together.
- R11: A memory request holds its address and direction until acknowledged, and an engine request stays high until done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 for write, 0 for read |
| mem_addr | output | ADDR_W | Byte address of the 32-bit word |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | One-cycle acknowledge |
| mem_rdata | input | 32 | Read data, valid with mem_ack |
| exe_req | output | 1 | Engine request, held until exe_done |
| exe_desc | output | 128 | Fetched descriptor |
| exe_done | input | 1 | One-cycle engine completion |
| exe_result | input | 32 | Outcome word for bytes 4 to 7 (bit 0 = success) |

## Verification
The ring is exercised with a plain run of three good entries, a run that wraps from the last index back to zero, failing entries with the error enable on and off, and a failing entry with the halt flag followed by a pending entry. Together these separate completion flagging from error flagging, show that wrap uses the programmed last index rather than the pointer width, and show that a halt stops at the right tail without touching the next entry. A scoreboard compares every descriptor handed to the engine and every write-back address and word against the entries the bench placed in memory. Another pass with run cleared and the head ahead shows that nothing moves without the run bit.

// File: rtl/desc_ring_pkg.sv
package desc_ring_pkg;
   // register offsets
   localparam logic [11:0] RA_BASE_LO = 12'h100;
   localparam logic [11:0] RA_BASE_HI = 12'h104;
   localparam logic [11:0] RA_CTRL    = 12'h108;
   localparam logic [11:0] RA_STAT    = 12'h10C;
   localparam logic [11:0] RA_SIZE    = 12'h110;

   // register bit positions
   localparam int PTR_LSB    = 16;
   localparam int CTRL_RUN   = 0;
   localparam int CTRL_ERRIE = 4;
   localparam int STAT_BUSY  = 0;
   localparam int STAT_ERR   = 4;
   localparam int STAT_DONE  = 5;

   // descriptor geometry
   localparam int DESC_WORDS = 4;
   localparam int WB_WORD    = 1;
   localparam int DC_IRQ     = 30;   // byte 3 bit 6 in word 0
   localparam int DC_HALT    = 31;   // byte 3 bit 7 in word 0
   localparam int RS_OK      = 0;

   typedef enum logic [1:0] {SQ_IDLE, SQ_FETCH, SQ_EXEC, SQ_WBACK} sq_state_e;
endpackage

// File: rtl/desc_ring_wrap.sv
module desc_ring_wrap #(
   parameter int PTR_W = 8
) (
   input  logic [PTR_W-1:0] cur,
   input  logic [PTR_W-1:0] last,
   output logic [PTR_W-1:0] nxt
);
   // an index at or beyond the last entry returns to zero
   assign nxt = (cur >= last) ? '0 : PTR_W'(cur + 1'b1);
endmodule

// File: rtl/desc_ring_regs.sv
module desc_ring_regs
   import desc_ring_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int PTR_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [11:0]       reg_addr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [PTR_W-1:0]  hw_tail,
   input  logic              hw_busy,
   input  logic              set_done,
   input  logic              set_err,
   input  logic              halt,
   output logic [ADDR_W-1:0] ring_base,
   output logic [PTR_W-1:0]  last_idx,
   output logic [PTR_W-1:0]  head_ptr,
   output logic              run_bit,
   output logic              err_ie
);
   logic [31:0]      base_lo_q, base_hi_q;
   logic [PTR_W-1:0] head_q, last_q;
   logic             run_q, errie_q, done_q, err_q;

   logic wr_lo, wr_hi, wr_ctrl, wr_stat, wr_size;
   assign wr_lo   = reg_wr && (reg_addr == RA_BASE_LO);
   assign wr_hi   = reg_wr && (reg_addr == RA_BASE_HI);
   assign wr_ctrl = reg_wr && (reg_addr == RA_CTRL);
   assign wr_stat = reg_wr && (reg_addr == RA_STAT);
   assign wr_size = reg_wr && (reg_addr == RA_SIZE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         base_lo_q <= '0;
         base_hi_q <= '0;
         head_q    <= '0;
         last_q    <= '0;
         run_q     <= 1'b0;
         errie_q   <= 1'b0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
      end else begin
         if (wr_lo) base_lo_q <= reg_wdata;
         if (wr_hi) base_hi_q <= reg_wdata;
         if (wr_size) last_q <= reg_wdata[PTR_W-1:0];
         if (wr_ctrl) begin
            head_q  <= reg_wdata[PTR_LSB +: PTR_W];
            errie_q <= reg_wdata[CTRL_ERRIE];
         end
         // a halt from the sequencer wins over a software write
         if (halt)         run_q <= 1'b0;
         else if (wr_ctrl) run_q <= reg_wdata[CTRL_RUN];
         // sticky flags: hardware set wins over write-1-to-clear
         done_q <= set_done | (done_q & ~(wr_stat & reg_wdata[STAT_DONE]));
         err_q  <= set_err  | (err_q  & ~(wr_stat & reg_wdata[STAT_ERR]));
      end
   end

   generate
      if (ADDR_W <= 32) begin : g_narrow
         assign ring_base = base_lo_q[ADDR_W-1:0];
      end else begin : g_wide
         assign ring_base = {base_hi_q[ADDR_W-33:0], base_lo_q};
      end
   endgenerate

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         RA_BASE_LO: reg_rdata = base_lo_q;
         RA_BASE_HI: reg_rdata = base_hi_q;
         RA_CTRL: begin
            reg_rdata[PTR_LSB +: PTR_W] = head_q;
            reg_rdata[CTRL_ERRIE]       = errie_q;
            reg_rdata[CTRL_RUN]         = run_q;
         end
         RA_STAT: begin
            reg_rdata[PTR_LSB +: PTR_W] = hw_tail;
            reg_rdata[STAT_DONE]        = done_q;
            reg_rdata[STAT_ERR]         = err_q;
            reg_rdata[STAT_BUSY]        = hw_busy;
         end
         RA_SIZE: reg_rdata[PTR_W-1:0] = last_q;
         default: reg_rdata = '0;
      endcase
   end

   assign last_idx = last_q;
   assign head_ptr = head_q;
   assign run_bit  = run_q;
   assign err_ie   = errie_q;
endmodule

// File: rtl/desc_ring_seq.sv
module desc_ring_seq
   import desc_ring_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int PTR_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     run_bit,
   input  logic                     err_ie,
   input  logic [PTR_W-1:0]         head_ptr,
   input  logic [PTR_W-1:0]         last_idx,
   input  logic [ADDR_W-1:0]        ring_base,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [31:0]              mem_wdata,
   input  logic                     mem_ack,
   input  logic [31:0]              mem_rdata,
   output logic                     exe_req,
   output logic [DESC_WORDS*32-1:0] exe_desc,
   input  logic                     exe_done,
   input  logic [31:0]              exe_result,
   output logic [PTR_W-1:0]         hw_tail,
   output logic                     hw_busy,
   output logic                     set_done,
   output logic                     set_err,
   output logic                     halt
);
   localparam int WIDX_W = $clog2(DESC_WORDS);

   sq_state_e        st_q;
   logic [WIDX_W-1:0] widx_q;
   logic [PTR_W-1:0] tail_q, tail_nxt;
   logic [31:0]      wb_q;
   logic [5:0]       word_off;
   logic             wb_ack, ok;

   desc_ring_wrap #(.PTR_W(PTR_W)) u_wrap (
      .cur (tail_q),
      .last(last_idx),
      .nxt (tail_nxt)
   );

   // one capture register per descriptor word
   generate
      for (genvar k = 0; k < DESC_WORDS; k++) begin : g_word
         logic [31:0] w_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) w_q <= '0;
            else if (st_q == SQ_FETCH && mem_ack && widx_q == WIDX_W'(k))
               w_q <= mem_rdata;
         end
         assign exe_desc[k*32 +: 32] = w_q;
      end
   endgenerate

   assign word_off  = (st_q == SQ_WBACK) ? 6'(WB_WORD * 4) : 6'({widx_q, 2'b00});
   assign mem_addr  = ring_base + ADDR_W'({tail_q, 4'b0000}) + ADDR_W'(word_off);
   assign mem_req   = (st_q == SQ_FETCH) || (st_q == SQ_WBACK);
   assign mem_we    = (st_q == SQ_WBACK);
   assign mem_wdata = wb_q;
   assign exe_req   = (st_q == SQ_EXEC);

   assign wb_ack   = (st_q == SQ_WBACK) && mem_ack;
   assign ok       = wb_q[RS_OK];
   assign set_done = wb_ack && exe_desc[DC_IRQ];
   assign set_err  = wb_ack && !ok && err_ie;
   assign halt     = wb_ack && !ok && exe_desc[DC_HALT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= SQ_IDLE;
         widx_q <= '0;
         tail_q <= '0;
         wb_q   <= '0;
      end else begin
         case (st_q)
            SQ_IDLE: if (run_bit && tail_q != head_ptr) begin
               st_q   <= SQ_FETCH;
               widx_q <= '0;
            end
            SQ_FETCH: if (mem_ack) begin
               widx_q <= widx_q + 1'b1;
               if (widx_q == WIDX_W'(DESC_WORDS - 1)) st_q <= SQ_EXEC;
            end
            SQ_EXEC: if (exe_done) begin
               wb_q <= exe_result;
               st_q <= SQ_WBACK;
            end
            SQ_WBACK: if (mem_ack) begin
               tail_q <= tail_nxt;
               widx_q <= '0;
               if (!halt && run_bit && tail_nxt != head_ptr) st_q <= SQ_FETCH;
               else                                          st_q <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
         endcase
      end
   end

   assign hw_tail = tail_q;
   assign hw_busy = (st_q != SQ_IDLE);
endmodule

// File: rtl/desc_ring_ctl.sv
module desc_ring_ctl
   import desc_ring_pkg::*;
#(
   parameter int ADDR_W = 64,
   parameter int PTR_W  = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     reg_wr,
   input  logic [11:0]              reg_addr,
   input  logic [31:0]              reg_wdata,
   output logic [31:0]              reg_rdata,
   output logic                     mem_req,
   output logic                     mem_we,
   output logic [ADDR_W-1:0]        mem_addr,
   output logic [31:0]              mem_wdata,
   input  logic                     mem_ack,
   input  logic [31:0]              mem_rdata,
   output logic                     exe_req,
   output logic [DESC_WORDS*32-1:0] exe_desc,
   input  logic                     exe_done,
   input  logic [31:0]              exe_result
);
   initial begin
      assert (ADDR_W >= 16 && ADDR_W <= 64) else $error("ADDR_W must lie in 16..64");
      assert (PTR_W >= 1 && PTR_W <= 8) else $error("PTR_W must lie in 1..8");
   end

   logic [PTR_W-1:0]  hw_tail, head_ptr, last_idx;
   logic [ADDR_W-1:0] ring_base;
   logic              hw_busy, set_done, set_err, halt, run_bit, err_ie;

   desc_ring_regs #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_regs (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .hw_tail(hw_tail), .hw_busy(hw_busy), .set_done(set_done), .set_err(set_err), .halt(halt),
      .ring_base(ring_base), .last_idx(last_idx), .head_ptr(head_ptr),
      .run_bit(run_bit), .err_ie(err_ie)
   );

   desc_ring_seq #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_seq (
      .clk(clk), .rst_n(rst_n),
      .run_bit(run_bit), .err_ie(err_ie), .head_ptr(head_ptr), .last_idx(last_idx),
      .ring_base(ring_base),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .exe_req(exe_req), .exe_desc(exe_desc), .exe_done(exe_done), .exe_result(exe_result),
      .hw_tail(hw_tail), .hw_busy(hw_busy),
      .set_done(set_done), .set_err(set_err), .halt(halt)
   );
endmodule

// File: rtl/desc_ring_ctl_chk.sv
module desc_ring_ctl_chk #(
   parameter int ADDR_W = 64,
   parameter int PTR_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_we,
   input logic              mem_ack,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              exe_req,
   input logic              exe_done,
   input logic [PTR_W-1:0]  hw_tail,
   input logic [PTR_W-1:0]  head_ptr,
   input logic              run_bit,
   input logic              hw_busy
);
   a_r11_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we));

   a_r11_exe_hold: assert property (@(posedge clk) disable iff (!rst_n)
      exe_req && !exe_done |=> exe_req);

   a_r5_wb_offset: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_addr[3:0] == 4'h4);

   a_r5_tail_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
      hw_tail != $past(hw_tail) |-> $past(mem_req && mem_we && mem_ack));

   a_r10_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hw_busy) |-> (hw_tail == head_ptr) || !run_bit);

   a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({mem_req, exe_req}));

   a_r4_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !hw_busy && !run_bit |=> !hw_busy);
endmodule

bind desc_ring_ctl desc_ring_ctl_chk #(.ADDR_W(ADDR_W), .PTR_W(PTR_W)) u_chk (
   .clk(clk), .rst_n(rst_n),
   .mem_req(mem_req), .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
   .exe_req(exe_req), .exe_done(exe_done),
   .hw_tail(hw_tail), .head_ptr(head_ptr), .run_bit(run_bit), .hw_busy(hw_busy)
);

// File: tb/desc_ring_ctl_test.sv
module desc_ring_ctl_test;
   localparam logic [63:0] BASE = 64'h0000_0001_0000_0400;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         reg_wr = 1'b0;
   logic [11:0]  reg_addr = '0;
   logic [31:0]  reg_wdata = '0;
   logic [31:0]  reg_rdata;
   logic         mem_req, mem_we;
   logic [63:0]  mem_addr;
   logic [31:0]  mem_wdata;
   logic         mem_ack = 1'b0;
   logic [31:0]  mem_rdata = '0;
   logic         exe_req;
   logic [127:0] exe_desc;
   logic         exe_done = 1'b0;
   logic [31:0]  exe_result = '0;

   int n_run = 0, n_fail = 0, exe_count = 0, exe_wait = 0;
   logic [31:0]  mem [1024];
   logic [127:0] exp_desc_q [$];
   logic [95:0]  exp_wb_q [$];

   always #2 clk = ~clk;   // 250 MHz

   desc_ring_ctl uut (
      .clk(clk), .rst_n(rst_n),
      .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .exe_req(exe_req), .exe_desc(exe_desc), .exe_done(exe_done), .exe_result(exe_result)
   );

   task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   // driver: writes an entry into memory and, if it should run, queues expectations
   task automatic put_desc(input int idx, input logic [7:0] ctl, input logic [7:0] outcome,
                           input bit will_run);
      logic [63:0] a;
      logic [7:0]  b0;
      logic [31:0] w0, w1, w2, w3;
      a  = BASE + 64'(idx * 16);
      b0 = 8'h30 + 8'(idx);
      w0 = {ctl, 8'h02, outcome, b0};
      w1 = 32'hDEAD_0000 | 32'(idx);
      w2 = 32'h1234_0000 + 32'(idx);
      w3 = 32'h0000_0001;
      mem[a[11:2]]     = w0;
      mem[a[11:2] + 1] = w1;
      mem[a[11:2] + 2] = w2;
      mem[a[11:2] + 3] = w3;
      if (will_run) begin
         exp_desc_q.push_back({w3, w2, w1, w0});
         exp_wb_q.push_back({a + 64'd4, {8'hA5, b0, 8'h02, outcome}});
      end
   endtask

   task automatic wait_idle();
      logic [31:0] s;
      repeat (3) @(negedge clk);
      for (int i = 0; i < 3000; i++) begin
         rd(12'h10C, s);
         if (!s[0]) break;
      end
   endtask

   // memory responder, driven just after the clock edge
   always @(posedge clk) begin
      #1;
      if (mem_req && !mem_ack) begin
         mem_ack = 1'b1;
         mem_rdata = mem[mem_addr[11:2]];
         if (mem_we) mem[mem_addr[11:2]] = mem_wdata;
      end else begin
         mem_ack = 1'b0;
      end
   end

   // transaction engine model: outcome from bytes 1,2,0 of the descriptor
   always @(posedge clk) begin
      #1;
      if (exe_req && !exe_done) begin
         exe_wait++;
         if (exe_wait >= 3) begin
            exe_done = 1'b1;
            exe_result = {8'hA5, exe_desc[7:0], exe_desc[23:16], exe_desc[15:8]};
            exe_wait = 0;
            exe_count++;
         end
      end else begin
         exe_done = 1'b0;
      end
   end

   // monitor: pops expectations as results appear
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req && mem_ack)
            chk("R2 ring base high half on access", 128'(mem_addr[63:12]), 128'(BASE[63:12]));
         if (exe_req && exe_done) begin
            if (exp_desc_q.size() == 0) chk("R9 unexpected entry executed", 1, 0);
            else chk("R2 descriptor words", exe_desc, exp_desc_q.pop_front());
         end
         if (mem_req && mem_we && mem_ack) begin
            if (exp_wb_q.size() == 0) chk("R9 unexpected write-back", 1, 0);
            else chk("R5 write-back address and word", {mem_addr, mem_wdata}, 128'(exp_wb_q.pop_front()));
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int c0;
      for (int i = 0; i < 1024; i++) mem[i] = '0;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd(12'h100, v); chk("R1 base low reset", v, 0);
      rd(12'h104, v); chk("R1 base high reset", v, 0);
      rd(12'h108, v); chk("R1 control reset", v, 0);
      rd(12'h10C, v); chk("R1 status reset", v, 0);
      rd(12'h110, v); chk("R1 size reset", v, 0);

      // R2 / R3 programming
      wr(12'h100, BASE[31:0]);
      wr(12'h104, BASE[63:32]);
      wr(12'h110, 32'd3);
      rd(12'h100, v); chk("R2 base low readback", v, BASE[31:0]);
      rd(12'h104, v); chk("R2 base high readback", v, BASE[63:32]);
      rd(12'h110, v); chk("R3 size readback", v, 32'd3);

      // R4 head ahead but run clear: nothing moves
      put_desc(0, 8'h40, 8'h01, 1);
      put_desc(1, 8'h00, 8'h01, 1);
      put_desc(2, 8'h00, 8'h01, 1);
      wr(12'h108, 32'h0003_0000);
      repeat (20) @(negedge clk);
      rd(12'h10C, v); chk("R4 run clear keeps tail and idle", v, 32'h0000_0000);
      chk("R4 run clear starts no entry", 128'(exe_count), 0);

      // R4 / R10 / R6 three good entries
      wr(12'h108, 32'h0003_0011);
      rd(12'h10C, v); chk("R10 busy during fetch", 128'(v[0]), 1);
      wait_idle();
      rd(12'h10C, v); chk("R4 R6 tail at head, completion set", v, 32'h0003_0020);
      chk("R4 three entries executed", 128'(exe_count), 3);

      // R8 write-1-to-clear
      wr(12'h10C, 32'h0000_0010);
      rd(12'h10C, v); chk("R8 clearing error bit leaves completion", v, 32'h0003_0020);
      wr(12'h10C, 32'h0000_0000);
      rd(12'h10C, v); chk("R8 writing zero keeps completion", v, 32'h0003_0020);
      wr(12'h10C, 32'h0000_0020);
      rd(12'h10C, v); chk("R8 completion cleared", v, 32'h0003_0000);

      // R3 / R7 wrap with a failing entry, error enable on
      put_desc(3, 8'h00, 8'h01, 1);
      put_desc(0, 8'h00, 8'h02, 1);
      wr(12'h108, 32'h0001_0011);
      wait_idle();
      rd(12'h10C, v); chk("R3 R7 wrap to head 1, error set, no completion", v, 32'h0001_0010);
      wr(12'h10C, 32'h0000_0030);

      // R7 failure with error enable off, completion requested
      put_desc(1, 8'h40, 8'h08, 1);
      wr(12'h108, 32'h0002_0001);
      wait_idle();
      rd(12'h10C, v); chk("R7 R6 error masked, completion set", v, 32'h0002_0020);
      wr(12'h10C, 32'h0000_0020);

      // R9 halt on failure
      c0 = exe_count;
      put_desc(2, 8'h80, 8'h02, 1);
      put_desc(3, 8'h40, 8'h01, 0);
      wr(12'h108, 32'h0000_0011);
      wait_idle();
      rd(12'h10C, v); chk("R9 tail past failed entry, error set", v, 32'h0003_0010);
      rd(12'h108, v); chk("R9 run cleared by halt", v, 32'h0000_0010);
      repeat (30) @(negedge clk);
      rd(12'h10C, v); chk("R9 tail holds after halt", v, 32'h0003_0010);
      chk("R9 single entry executed", 128'(exe_count - c0), 1);
      wr(12'h10C, 32'h0000_0010);

      // R3 resume and wrap to zero
      put_desc(3, 8'h40, 8'h01, 1);
      wr(12'h108, 32'h0000_0001);
      wait_idle();
      rd(12'h10C, v); chk("R3 resume wraps tail to 0", v, 32'h0000_0020);
      chk("R5 all expected write-backs seen", 128'(exp_wb_q.size()), 0);
      chk("R2 all expected descriptors seen", 128'(exp_desc_q.size()), 0);

      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule